// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a bank of byte-wide configuration registers that a processor reaches through two I/O ports. The processor first writes an index value to the index port and then reads or writes one register through the data port. The index is offset by a fixed base, so only a small window of index values selects a register. Any other value selects nothing.

The index can be used for one access only. Every data-port access, read or write, puts the index back to its all-ones value. Each register access therefore needs its own index write first. Some registers keep part of their contents on a write. A write to any of the memory-map registers sends a one-cycle strobe, which tells the downstream address decoders to recompute their windows. The control register drives two signals straight out of the block: a two-bit bus clock divider select and a halt-reset enable.

Top module: `cfg_index_port`

## Requirements
- R1: A write strobe with address 0x22 loads the 8-bit index from the write data.
- R2: Any read or write strobe at address 0x24 sets the index to 0xFF once the access completes. A second data access with no new index write in between therefore selects no register: a read returns 0xFF and a write changes nothing.
- R3: The register number is the index minus 0x70, taken modulo 256. Only register numbers 0 to 11 exist. A data read of any other number returns 0xFF, and a data write to any other number changes no register.
- R4: A write to register 0 replaces only bits 5:0. Bits 7:6 keep their previous value.
- R5: After reset, register 0 is 0x1F, register 1 is 0x8F, register 2 is 0xF0, and registers 7 and 9 are 0x70. Every other register is 0x00, the index is 0xFF and the read data is 0xFF.
- R6: A data write to register 2, 3, 4 or 5 raises `map_update` for exactly the one cycle after the write strobe. A write to any other register, or a write that selects no register, leaves it low.
- R7: `clk_div_sel` always equals bits 1:0 of register 6, with these codes: 00 means divide by 8, 01 by 6, 10 by 5 and 11 by 4. `halt_reset_en` always equals bit 6 of register 6.
- R8: Read data is registered. It shows the result of a read strobe in the cycle after the strobe and holds that value until the next read that the block answers. A read strobe at the index port returns 0xFF.
- R9: A strobe at any address other than 0x22 and 0x24 changes neither the index, nor any register, nor the read data.
- R10: A write to register 1, 2, 3, 4, 5, 6, 7, 8, 9, 10 or 11 stores the whole byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 8 | I/O address of the current strobe |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_regs | output | 96 | All registers; register n occupies bits 8n+7:8n |
| map_update | output | 1 | One-cycle strobe after a memory-map register write |
| clk_div_sel | output | 2 | Bus clock divisor select (register 6 bits 1:0) |
| halt_reset_en | output | 1 | Reset-on-halt enable (register 6 bit 6) |

## Verification
The hardest situation to reach is a data access whose index has gone stale. A single access never shows whether the index was consumed, so the stimulus has to put two data-port accesses back to back with no index write between them, and also wrap foreign-address strobes around a valid index. Directed sequences build these patterns explicitly: read twice, write twice, and write the index, then touch a foreign port, then access data. A random phase then draws its index values from just below and just above the 0x70 window, so that the wrap of the subtraction and the limit of 11 are crossed many times. The reference model in the bench checks every cycle.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   // Kind of access presented on the strobe interface in one cycle
   typedef enum logic [2:0] {
      ACC_NONE    = 3'd0,
      ACC_IDX_WR  = 3'd1,
      ACC_IDX_RD  = 3'd2,
      ACC_DATA_WR = 3'd3,
      ACC_DATA_RD = 3'd4,
      ACC_FOREIGN = 3'd5
   } acc_kind_e;

   // Reset contents of register n (R5)
   function automatic logic [31:0] cfg_reset_value(input int unsigned n);
      case (n)
         0:       return 32'h1F;
         1:       return 32'h8F;
         2:       return 32'hF0;
         7:       return 32'h70;
         9:       return 32'h70;
         default: return 32'h00;
      endcase
   endfunction

   // Bits of register n that a data write leaves untouched (R4)
   function automatic logic [31:0] cfg_keep_mask(input int unsigned n);
      return (n == 0) ? 32'hC0 : 32'h00;
   endfunction

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
   import cfg_port_pkg::*;
#(
   parameter int unsigned         ADDR_W     = 8,
   parameter logic [ADDR_W-1:0]   INDEX_PORT = 'h22,
   parameter logic [ADDR_W-1:0]   DATA_PORT  = 'h24
) (
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [ADDR_W-1:0] io_addr,
   output acc_kind_e         acc
);

   logic at_index;
   logic at_data;

   assign at_index = (io_addr == INDEX_PORT);
   assign at_data  = (io_addr == DATA_PORT);

   // A write strobe wins over a read strobe in the same cycle
   always_comb begin
      acc = ACC_NONE;
      if (io_wr) begin
         if (at_index)     acc = ACC_IDX_WR;
         else if (at_data) acc = ACC_DATA_WR;
         else              acc = ACC_FOREIGN;
      end else if (io_rd) begin
         if (at_index)     acc = ACC_IDX_RD;
         else if (at_data) acc = ACC_DATA_RD;
         else              acc = ACC_FOREIGN;
      end
   end

endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
   import cfg_port_pkg::*;
#(
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       NUM_REGS = 12,
   parameter logic [DATA_W-1:0] REG_BASE = 'h70
) (
   input  logic                clk,
   input  logic                rst_n,
   input  acc_kind_e           acc,
   input  logic [DATA_W-1:0]   io_wdata,
   output logic [DATA_W-1:0]   index_q,
   output logic [NUM_REGS-1:0] sel,
   output logic                hit
);

   logic [DATA_W-1:0] reg_num;

   // One-shot index: loaded by the index port, consumed by any data access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '1;
      end else begin
         case (acc)
            ACC_IDX_WR:              index_q <= io_wdata;
            ACC_DATA_WR, ACC_DATA_RD: index_q <= '1;
            default:                 index_q <= index_q;
         endcase
      end
   end

   assign reg_num = index_q - REG_BASE;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign sel[i] = (reg_num == DATA_W'(i));
   end

   assign hit = |sel;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfg_port_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_REGS  = 12,
   parameter int unsigned MEM_FIRST = 2,
   parameter int unsigned MEM_LAST  = 5,
   localparam int unsigned FLAT_W   = NUM_REGS * DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [NUM_REGS-1:0] sel,
   input  logic [DATA_W-1:0]   io_wdata,
   output logic [FLAT_W-1:0]   regs_flat,
   output logic                map_update
);

   logic [NUM_REGS-1:0] mem_sel;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [DATA_W-1:0] RST_VAL  = DATA_W'(cfg_reset_value(i));
      localparam logic [DATA_W-1:0] KEEP_MSK = DATA_W'(cfg_keep_mask(i));
      logic [DATA_W-1:0] q;

      if (KEEP_MSK == '0) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= RST_VAL;
            else if (wr_en && sel[i])  q <= io_wdata;
         end
      end else begin : g_masked
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= RST_VAL;
            else if (wr_en && sel[i])  q <= (q & KEEP_MSK) | (io_wdata & ~KEEP_MSK);
         end
      end

      assign regs_flat[i*DATA_W +: DATA_W] = q;

      if ((i >= MEM_FIRST) && (i <= MEM_LAST)) begin : g_mem
         assign mem_sel[i] = sel[i];
      end else begin : g_plain
         assign mem_sel[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_update <= 1'b0;
      else        map_update <= wr_en && (|mem_sel);
   end

endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 12,
   localparam int unsigned FLAT_W  = NUM_REGS * DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  acc_kind_e           acc,
   input  logic [NUM_REGS-1:0] sel,
   input  logic                hit,
   input  logic [FLAT_W-1:0]   regs_flat,
   output logic [DATA_W-1:0]   io_rdata
);

   logic [DATA_W-1:0] mux_val;

   always_comb begin
      mux_val = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (sel[i]) mux_val = mux_val | regs_flat[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_rdata <= '1;
      end else begin
         case (acc)
            ACC_DATA_RD: io_rdata <= hit ? mux_val : '1;
            ACC_IDX_RD:  io_rdata <= '1;
            default:     io_rdata <= io_rdata;
         endcase
      end
   end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 8,
   parameter int unsigned        DATA_W     = 8,
   parameter int unsigned        NUM_REGS   = 12,
   parameter logic [ADDR_W-1:0]  INDEX_PORT = 'h22,
   parameter logic [ADDR_W-1:0]  DATA_PORT  = 'h24,
   parameter logic [DATA_W-1:0]  REG_BASE   = 'h70,
   parameter int unsigned        MEM_FIRST  = 2,
   parameter int unsigned        MEM_LAST   = 5,
   parameter int unsigned        CTRL_REG   = 6,
   parameter int unsigned        DIV_W      = 2,
   parameter int unsigned        HALT_BIT   = 6,
   localparam int unsigned       FLAT_W     = NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic [FLAT_W-1:0] cfg_regs,
   output logic              map_update,
   output logic [DIV_W-1:0]  clk_div_sel,
   output logic              halt_reset_en
);

   // Elaboration-time parameter checks
   if (NUM_REGS < 1 || NUM_REGS > (1 << DATA_W)) begin : g_bad_num
      $error("cfg_index_port: NUM_REGS out of range");
   end
   if (INDEX_PORT == DATA_PORT) begin : g_bad_ports
      $error("cfg_index_port: index and data ports must differ");
   end
   if (MEM_FIRST > MEM_LAST || MEM_LAST >= NUM_REGS) begin : g_bad_mem
      $error("cfg_index_port: memory-map register range invalid");
   end
   if (CTRL_REG >= NUM_REGS || DIV_W > DATA_W || HALT_BIT >= DATA_W) begin : g_bad_ctrl
      $error("cfg_index_port: control register fields invalid");
   end

   acc_kind_e           acc;
   logic [DATA_W-1:0]   index_q;
   logic [NUM_REGS-1:0] sel;
   logic                hit;
   logic [DATA_W-1:0]   ctrl_q;

   cfg_access_decode #(
      .ADDR_W    (ADDR_W),
      .INDEX_PORT(INDEX_PORT),
      .DATA_PORT (DATA_PORT)
   ) u_decode (
      .io_wr  (io_wr),
      .io_rd  (io_rd),
      .io_addr(io_addr),
      .acc    (acc)
   );

   cfg_index_reg #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .REG_BASE(REG_BASE)
   ) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .io_wdata(io_wdata),
      .index_q (index_q),
      .sel     (sel),
      .hit     (hit)
   );

   cfg_reg_bank #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .MEM_FIRST(MEM_FIRST),
      .MEM_LAST (MEM_LAST)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (acc == ACC_DATA_WR),
      .sel       (sel),
      .io_wdata  (io_wdata),
      .regs_flat (cfg_regs),
      .map_update(map_update)
   );

   cfg_read_port #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS)
   ) u_read (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .sel      (sel),
      .hit      (hit),
      .regs_flat(cfg_regs),
      .io_rdata (io_rdata)
   );

   assign ctrl_q        = cfg_regs[CTRL_REG*DATA_W +: DATA_W];
   assign clk_div_sel   = ctrl_q[DIV_W-1:0];
   assign halt_reset_en = ctrl_q[HALT_BIT];

endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       NUM_REGS   = 12,
   parameter logic [ADDR_W-1:0] INDEX_PORT = 'h22,
   parameter logic [ADDR_W-1:0] DATA_PORT  = 'h24,
   parameter logic [DATA_W-1:0] REG_BASE   = 'h70,
   parameter int unsigned       MEM_FIRST  = 2,
   parameter int unsigned       MEM_LAST   = 5,
   localparam int unsigned      FLAT_W     = NUM_REGS * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic [FLAT_W-1:0] cfg_regs,
   input logic              map_update,
   input logic [DATA_W-1:0] index_q
);

   logic              past_valid;
   logic [DATA_W-1:0] num;
   logic              in_window;
   logic              in_mem;
   logic              data_acc;
   logic              foreign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   assign num       = index_q - REG_BASE;
   assign in_window = (32'(num) < NUM_REGS);
   assign in_mem    = (32'(num) >= MEM_FIRST) && (32'(num) <= MEM_LAST);
   assign data_acc  = (io_wr || io_rd) && (io_addr == DATA_PORT);
   assign foreign   = (io_wr || io_rd) && (io_addr != DATA_PORT) && (io_addr != INDEX_PORT);

   assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == INDEX_PORT) |=> (index_q == $past(io_wdata)));

   assert_index_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc |=> (index_q == '1));

   assert_miss_reads_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !io_wr && io_addr == DATA_PORT && !in_window) |=> (io_rdata == '1));

   assert_lock_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> $stable(cfg_regs[7:6]));

   assert_map_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == DATA_PORT && in_mem) |=> map_update);

   assert_map_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      map_update |=> !map_update);

   assert_index_port_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !io_wr && io_addr == INDEX_PORT) |=> (io_rdata == '1));

   assert_foreign_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      foreign |=> ($stable(index_q) && $stable(cfg_regs) && $stable(io_rdata)));

endmodule

bind cfg_index_port cfg_index_port_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_REGS  (NUM_REGS),
   .INDEX_PORT(INDEX_PORT),
   .DATA_PORT (DATA_PORT),
   .REG_BASE  (REG_BASE),
   .MEM_FIRST (MEM_FIRST),
   .MEM_LAST  (MEM_LAST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_addr   (io_addr),
   .io_wr     (io_wr),
   .io_rd     (io_rd),
   .io_wdata  (io_wdata),
   .io_rdata  (io_rdata),
   .cfg_regs  (cfg_regs),
   .map_update(map_update),
   .index_q   (index_q)
);

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = 8'h00;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic [95:0] cfg_regs;
   logic        map_update;
   logic [1:0]  clk_div_sel;
   logic        halt_reset_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit cmp_on   = 1'b0;

   always #5 clk = ~clk;

   cfg_index_port dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .io_addr      (io_addr),
      .io_wr        (io_wr),
      .io_rd        (io_rd),
      .io_wdata     (io_wdata),
      .io_rdata     (io_rdata),
      .cfg_regs     (cfg_regs),
      .map_update   (map_update),
      .clk_div_sel  (clk_div_sel),
      .halt_reset_en(halt_reset_en)
   );

   // ---------------- behavioural reference model ----------------
   int m_idx;
   int m_reg [12];
   int m_rdata;
   bit m_map;

   always @(posedge clk or negedge rst_n) begin
      int n;
      if (!rst_n) begin
         m_idx   <= 255;
         m_rdata <= 255;
         m_map   <= 1'b0;
         foreach (m_reg[i]) m_reg[i] <= 0;
         m_reg[0] <= 'h1F; m_reg[1] <= 'h8F; m_reg[2] <= 'hF0;
         m_reg[7] <= 'h70; m_reg[9] <= 'h70;
      end else begin
         n = (m_idx - 'h70) & 255;
         m_map <= 1'b0;
         if (io_wr) begin
            if (io_addr == 8'h22) m_idx <= int'(io_wdata);
            else if (io_addr == 8'h24) begin
               if (n < 12) begin
                  if (n == 0) m_reg[0] <= (m_reg[0] & 'hC0) | (int'(io_wdata) & 'h3F);
                  else        m_reg[n] <= int'(io_wdata);
                  if (n >= 2 && n <= 5) m_map <= 1'b1;
               end
               m_idx <= 255;
            end
         end else if (io_rd) begin
            if (io_addr == 8'h24) begin
               m_rdata <= (n < 12) ? m_reg[n] : 255;
               m_idx   <= 255;
            end else if (io_addr == 8'h22) m_rdata <= 255;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         logic [95:0] exp_flat;
         foreach (m_reg[i]) exp_flat[i*8 +: 8] = 8'(m_reg[i]);
         chk("R8 io_rdata", int'(io_rdata), m_rdata);
         chk("R6 map_update", int'(map_update), int'(m_map));
         chk("R7 clk_div_sel", int'(clk_div_sel), m_reg[6] & 3);
         chk("R7 halt_reset_en", int'(halt_reset_en), (m_reg[6] >> 6) & 1);
         n_checks++;
         if (cfg_regs !== exp_flat) begin
            n_fail++;
            $display("FAIL R3/R4/R10 cfg_regs actual=%h expected=%h", cfg_regs, exp_flat);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic access(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
   endtask

   task automatic set_index(input logic [7:0] v);
      access(1'b1, 1'b0, 8'h22, v);
   endtask

   task automatic wr_data(input logic [7:0] v);
      access(1'b1, 1'b0, 8'h24, v);
   endtask

   task automatic rd_data(output logic [7:0] v);
      access(1'b0, 1'b1, 8'h24, 8'h00);
      v = io_rdata;
   endtask

   task automatic rd_reg(input int r, output logic [7:0] v);
      set_index(8'(8'h70 + r));
      rd_data(v);
   endtask

   task automatic wr_reg(input int r, input logic [7:0] d);
      set_index(8'(8'h70 + r));
      wr_data(d);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   // ---------------- directed and random sequence ----------------
   initial begin
      logic [7:0] v;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      chk("R5 reset rdata", int'(io_rdata), 'hFF);
      chk("R5 reset map_update", int'(map_update), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R5: reset contents through the port
      for (int r = 0; r < 12; r++) begin
         int e;
         e = (r == 0) ? 'h1F : (r == 1) ? 'h8F : (r == 2) ? 'hF0 :
             (r == 7 || r == 9) ? 'h70 : 0;
         rd_reg(r, v);
         chk("R5 reset value", int'(v), e);
      end
      chk("R7 reset divider code 00 (/8)", int'(clk_div_sel), 0);

      // R1/R2: index consumed by a read
      rd_reg(1, v);
      chk("R1 indexed read", int'(v), 'h8F);
      rd_data(v);
      chk("R2 stale read", int'(v), 'hFF);

      // R2/R10: second write without new index is dropped
      wr_reg(8, 8'h55);
      wr_data(8'hAA);
      rd_reg(8, v);
      chk("R10 full byte / R2 stale write", int'(v), 'h55);

      // R3: below and above the window
      set_index(8'h6F);
      rd_data(v);
      chk("R3 index below base", int'(v), 'hFF);
      wr_reg(12, 8'h12);
      rd_reg(12, v);
      chk("R3 register 12 absent", int'(v), 'hFF);
      set_index(8'h00);
      wr_data(8'h34);
      chk("R3 wrapped index no write", int'(cfg_regs[7:0]), 'h1F);

      // R4: upper bits of register 0 kept
      wr_reg(0, 8'hFF);
      rd_reg(0, v);
      chk("R4 reg0 masked write", int'(v), 'h3F);
      wr_reg(0, 8'hC0);
      rd_reg(0, v);
      chk("R4 reg0 clear low bits", int'(v), 'h00);

      // R6: strobe only for memory-map registers
      for (int r = 0; r < 12; r++) begin
         wr_reg(r, 8'(8'hA0 + r));
         chk("R6 strobe after write", int'(map_update), (r >= 2 && r <= 5) ? 1 : 0);
         @(negedge clk);
         chk("R6 strobe one cycle", int'(map_update), 0);
      end
      set_index(8'hFF);
      wr_data(8'h01);
      chk("R6 no strobe on miss", int'(map_update), 0);

      // R7: divider codes and halt enable
      for (int c = 0; c < 4; c++) begin
         wr_reg(6, 8'(8'h40 | c));
         chk("R7 divider select", int'(clk_div_sel), c);
         chk("R7 halt enable set", int'(halt_reset_en), 1);
      end
      wr_reg(6, 8'hBF);
      chk("R7 halt enable clear", int'(halt_reset_en), 0);
      chk("R7 divider code 11 (/4)", int'(clk_div_sel), 3);

      // R8: read data held, index port read returns FF
      rd_reg(2, v);
      held = v;
      repeat (4) @(negedge clk);
      chk("R8 read data held", int'(io_rdata), int'(held));
      access(1'b0, 1'b1, 8'h22, 8'h00);
      chk("R8 index port read", int'(io_rdata), 'hFF);

      // R9: foreign strobes do not touch index, registers or read data
      rd_reg(1, v);
      set_index(8'h72);
      access(1'b1, 1'b0, 8'h23, 8'h99);
      access(1'b0, 1'b1, 8'h21, 8'h00);
      chk("R9 rdata unchanged", int'(io_rdata), int'(v));
      rd_data(v);
      chk("R9 index preserved", int'(v), 'hA2);

      // Random phase, compared every cycle against the model
      for (int k = 0; k < 3000; k++) begin
         int sel;
         logic [7:0] a;
         logic [7:0] d;
         sel = int'($urandom_range(0, 9));
         d   = 8'($urandom);
         if (sel < 3) begin a = 8'h22; d = 8'(8'h6C + $urandom_range(0, 20)); end
         else if (sel < 8) a = 8'h24;
         else a = 8'($urandom);
         @(negedge clk);
         io_addr = a; io_wdata = d;
         io_wr = ($urandom_range(0, 1) == 1);
         io_rd = !io_wr && ($urandom_range(0, 3) != 0);
      end
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      repeat (3) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule